// File: doc/BRIEF.md
# SPI Master Controller

This block is a byte-wide SPI master with four registers on a simple synchronous bus: control, status, data and a rate extension. Writing the data register while the controller is enabled and idle shifts that byte out on `mosi`, most significant bit first. In the same transfer it shifts a byte in from `miso`. It drives `sclk` with a programmable idle level and sampling phase, at one of sixteen divided rates. It holds `ss_n` low for the length of the transfer.

A finished byte moves into a receive holding register. A new transfer can therefore run while software still has the last byte to read. Status flags report three events: transfer done, a data write that collided with a running transfer, and a mode fault. A mode fault happens when another master pulls the shared select line `ss_in_n` low. Done and mode fault drive `irq` when interrupts are enabled. The bus inputs and `miso`/`ss_in_n` are taken as synchronous to `clk`.

Top module: `spi_master_ctl`

## Requirements
- R1: After reset:
  - control (addr 0) reads 0x10;
  - status (addr 1) reads 0x05;
  - extension (addr 3) reads 0x00;
  - `irq` is 0, `ss_n` is 1 and `sclk` is 0.
- R2: Control bits are:
  - bit 7 interrupt enable;
  - bit 6 controller enable;
  - bit 5 a read/write spare;
  - bit 4 reads 1 always and ignores writes;
  - bit 3 clock idle level;
  - bit 2 clock phase;
  - bits 1:0 low rate select.

  Extension bits 1:0 hold the high rate select, and its other bits read 0.
- R3: With rate index i = {ext[1:0], ctrl[1:0]}, one SCLK period lasts 2, 4, 16, 32, 8, 64, 128, 256 clock cycles for i = 0..7 and 2^(i+1) for i = 8..15. A byte therefore keeps `ss_n` low for exactly 8 periods.
- R4: `sclk` rests at the idle level whenever no transfer runs. Each byte has 16 edges and ends with `sclk` back at the idle level.
- R5: With phase 0, `mosi` shows bit 7 from the start. `miso` is sampled on edges 1, 3, ..., 15, and `mosi` advances on edges 2, 4, ..., 14.
- R6: With phase 1, `miso` is sampled on edges 2, 4, ..., 16, and `mosi` advances on edges 3, 5, ..., 15.
- R7: A data write (addr 2) starts a transfer only when enable is 1 and no transfer runs. With enable 0 it has no effect.
- R8: A data write during a transfer sets status bit 6. The write is discarded and the running byte is unchanged.
- R9: At the end of a byte:
  - the received byte enters the holding register;
  - status bit 7 is set;
  - status bit 0 ("receive empty") goes to 0.

  Reading addr 2 returns the held byte and sets bit 0 again. The held byte stays readable during the next transfer, and a newer completed byte replaces it.
- R10: Status bits 7, 6 and 4 clear when written with 1 and do not change when written with 0. A setting event in the same cycle wins.
- R11: `ss_in_n` low while enable is 1 causes a mode fault:
  - status bit 4 is set;
  - the enable bit is cleared;
  - any transfer is aborted without setting bit 7 or loading the holding register.
- R12: `irq` is 1 exactly when interrupt enable is 1 and status bit 7 or bit 4 is set. Bit 6 never raises `irq`.
- R13: Status bit 2 ("transmit empty") reads 1 exactly when no transfer runs. Status bits 5, 3 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (pops receive data at addr 2) |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select, low during a transfer |
| ss_in_n | input | 1 | Shared select line watched for mode faults |

## Verification
The bench loops `mosi` back to `miso` in both phases, so any misplaced sample edge returns a corrupted byte instead of the sent one. It times `ss_n` across several rate indices, including one that uses the extension bits, which exposes a wrong divider entry or an uneven half period. It writes data mid-transfer, reads the holding register while the next byte shifts, and pulls the select line low mid-byte. A design that let a colliding write overwrite the shifter would show this, as would one that lost the held byte or completed an aborted transfer. A cycle-level model checks every output on each clock against random `miso` data.

// File: rtl/spi_master_ctl.sv
module spi_master_ctl #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          ss_n,
  input  logic          ss_in_n
);
  localparam int EW = $clog2(2*DW);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW-1);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_EXT = 2'd3;

  logic ie, en, spare, cpol, cpha;
  logic [1:0] rlo, rhi;
  logic f_done, f_wcol, f_modf, rx_valid, busy, ph;
  logic [DW-1:0] txsh, rxsh, rxbuf;
  logic [EW-1:0] edge_n;
  logic [CW-1:0] cnt, half;
  logic [4:0] shamt;

  always_comb begin
    case ({rhi, rlo})
      4'd0: shamt = 5'd1;
      4'd1: shamt = 5'd2;
      4'd2: shamt = 5'd4;
      4'd3: shamt = 5'd5;
      4'd4: shamt = 5'd3;
      4'd5: shamt = 5'd6;
      4'd6: shamt = 5'd7;
      4'd7: shamt = 5'd8;
      default: shamt = {1'b0, rhi, rlo} + 5'd1;
    endcase
  end
  assign half = CW'(1) << (shamt - 5'd1);

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_stat = bus_we && bus_addr == A_STAT;
  wire wr_data = bus_we && bus_addr == A_DATA;
  wire wr_ext  = bus_we && bus_addr == A_EXT;
  wire rd_data = bus_re && bus_addr == A_DATA;
  wire tick    = busy && cnt == half - CW'(1);
  wire last    = tick && edge_n == LAST_EDGE;
  wire samp    = tick && (edge_n[0] == cpha);
  wire shft    = tick && (edge_n[0] != cpha) && !last && edge_n != '0;
  wire fault   = en && !ss_in_n;
  wire [DW-1:0] rx_next = {rxsh[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie, en, spare, cpol, cpha} <= '0;
      rlo <= '0; rhi <= '0;
      {f_done, f_wcol, f_modf, rx_valid, busy, ph} <= '0;
      txsh <= '0; rxsh <= '0; rxbuf <= '0;
      edge_n <= '0; cnt <= '0;
    end else begin
      if (wr_ctrl) {ie, en, spare, cpol, cpha, rlo} <= {bus_wdata[7:5], bus_wdata[3:0]};
      if (wr_ext) rhi <= bus_wdata[1:0];
      if (wr_stat) begin
        if (bus_wdata[7]) f_done <= 1'b0;
        if (bus_wdata[6]) f_wcol <= 1'b0;
        if (bus_wdata[4]) f_modf <= 1'b0;
      end
      if (rd_data) rx_valid <= 1'b0;
      if (wr_data) begin
        if (busy) f_wcol <= 1'b1;
        else if (en) begin
          busy <= 1'b1; txsh <= bus_wdata; cnt <= '0; edge_n <= '0; ph <= 1'b0;
        end
      end
      if (busy) begin
        if (tick) begin
          cnt <= '0; ph <= ~ph; edge_n <= edge_n + EW'(1);
        end else cnt <= cnt + CW'(1);
        if (samp) rxsh <= rx_next;
        if (shft) txsh <= {txsh[DW-2:0], 1'b0};
        if (last) begin
          busy <= 1'b0; rxbuf <= cpha ? rx_next : rxsh; rx_valid <= 1'b1; f_done <= 1'b1;
        end
      end
      if (!en) busy <= 1'b0;
      if (fault) begin
        f_modf <= 1'b1; en <= 1'b0; busy <= 1'b0;
      end
    end
  end

  assign sclk = busy ? cpol ^ ph : cpol;
  assign mosi = txsh[DW-1];
  assign ss_n = ~busy;
  assign irq  = ie & (f_done | f_modf);

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = DW'({ie, en, spare, 1'b1, cpol, cpha, rlo});
      A_STAT:  bus_rdata = DW'({f_done, f_wcol, 1'b0, f_modf, 1'b0, ~busy, 1'b0, ~rx_valid});
      A_DATA:  bus_rdata = rxbuf;
      default: bus_rdata = DW'(rhi);
    endcase
  end

  // R3: no SCLK movement between divider ticks
  a_r3_sclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick && en && !fault && !wr_ctrl) |=> $stable(sclk));
  // R4: sixteen toggles bring the phase back to idle
  a_r4_even_edges: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !ph);
  // R7: accepted write starts the byte
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && en && !busy && ss_in_n) |=> (busy && !ss_n));
  // R8: collision is flagged
  a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && busy) |=> f_wcol);
  // R9: completion fills the holding register
  a_r9_complete: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (rx_valid && f_done && ss_n));
  // R11: fault disables and aborts
  a_r11_fault: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!en && ss_n && f_modf));
endmodule

// File: tb/tb_spi_master_ctl.sv
module tb_spi_master_ctl;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_we = 0, bus_re = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq, sclk, mosi, ss_n;
  logic ss_in_n = 1, lb = 1;
  logic [15:0] lfsr = 16'hACE1;
  wire miso = lb ? mosi : lfsr[0];
  int n_chk = 0, n_fail = 0, lowcnt = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  spi_master_ctl dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ss_n(ss_n), .ss_in_n(ss_in_n));

  always @(posedge clk) begin #1ns; lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]}; end
  always @(negedge clk) if (!ss_n) lowcnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  logic [7:0] m_ctrl = 8'h10, m_ext = 0, m_rxbuf = 0, m_tx = 0, m_rx = 0;
  bit m_done, m_wcol, m_modf, m_rxv, m_busy;
  int m_t = 0, m_bit = 0;

  function automatic int half_of(input logic [3:0] idx);
    int s;
    case (idx)
      0: s = 1; 1: s = 2; 2: s = 4; 3: s = 5;
      4: s = 3; 5: s = 6; 6: s = 7; 7: s = 8;
      default: s = int'(idx) + 1;
    endcase
    return 1 << (s - 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h10; m_ext = 0; m_rxbuf = 0; m_tx = 0; m_rx = 0;
      m_done = 0; m_wcol = 0; m_modf = 0; m_rxv = 0; m_busy = 0; m_t = 0; m_bit = 0;
    end else begin
      bit o_en, o_cpha, o_busy;
      int hp, k;
      o_en = m_ctrl[6]; o_cpha = m_ctrl[2]; o_busy = m_busy;
      hp = half_of({m_ext[1:0], m_ctrl[1:0]});
      if (bus_we && bus_addr == 0) m_ctrl = (bus_wdata & 8'hEF) | 8'h10;
      if (bus_we && bus_addr == 3) m_ext = {6'b0, bus_wdata[1:0]};
      if (bus_we && bus_addr == 1) begin
        if (bus_wdata[7]) m_done = 0;
        if (bus_wdata[6]) m_wcol = 0;
        if (bus_wdata[4]) m_modf = 0;
      end
      if (bus_re && bus_addr == 2) m_rxv = 0;
      if (bus_we && bus_addr == 2) begin
        if (o_busy) m_wcol = 1;
        else if (o_en) begin m_busy = 1; m_tx = bus_wdata; m_t = 0; m_bit = 0; end
      end
      if (o_busy) begin
        m_t++;
        if (m_t % hp == 0) begin
          k = m_t / hp - 1;
          if (k % 2 == int'(o_cpha)) m_rx = {m_rx[6:0], miso};
          else if (k != 0 && k != 15) m_bit++;
          if (k == 15) begin m_busy = 0; m_rxbuf = m_rx; m_rxv = 1; m_done = 1; end
        end
      end
      if (!o_en) m_busy = 0;
      if (o_en && !ss_in_n) begin m_modf = 1; m_ctrl[6] = 0; m_busy = 0; end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    int hp;
    logic [7:0] er;
    hp = half_of({m_ext[1:0], m_ctrl[1:0]});
    case (bus_addr)
      0: er = m_ctrl;
      1: er = {m_done, m_wcol, 1'b0, m_modf, 1'b0, !m_busy, 1'b0, !m_rxv};
      2: er = m_rxbuf;
      default: er = m_ext;
    endcase
    chk("R4 ss_n", ss_n, !m_busy);
    chk("R4 sclk", sclk, m_busy ? (m_ctrl[3] ^ ((m_t / hp) % 2)) : m_ctrl[3]);
    chk("R5 mosi", mosi, m_tx[7 - m_bit]);
    chk("R12 irq", irq, m_ctrl[7] && (m_done || m_modf));
    chk("R2 rdata", bus_rdata, er);
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1ns; bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1ns; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1ns; bus_addr = a; bus_re = 1;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1ns; bus_re = 0;
  endtask

  task automatic xfer(input logic [7:0] d, output int cyc);
    lowcnt = 0;
    bus_wr(2, d);
    while (ss_n == 0) @(negedge clk);
    cyc = lowcnt;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int c;
    repeat (4) @(posedge clk);
    #1ns rst_n = 1;
    @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 ss_n", ss_n, 1); chk("R1 sclk", sclk, 0);
    bus_rd(0, v); chk("R1 ctrl", v, 8'h10);
    bus_rd(1, v); chk("R1 status", v, 8'h05);
    bus_rd(3, v); chk("R1 ext", v, 8'h00);

    bus_wr(0, 8'hEF); bus_rd(0, v); chk("R2 ctrl bit4 fixed", v, 8'hFF);
    bus_wr(0, 8'h00); bus_rd(0, v); chk("R2 ctrl clear", v, 8'h10);
    bus_wr(3, 8'hFE); bus_rd(3, v); chk("R2 ext", v, 8'h02);
    bus_wr(3, 8'h00);

    bus_wr(2, 8'hA5); repeat (4) @(negedge clk);
    chk("R7 disabled write ignored", ss_n, 1);
    bus_rd(1, v); chk("R7 status unchanged", v, 8'h05);

    bus_wr(0, 8'hC0);
    xfer(8'hA5, c); chk("R3 idx0 length", c, 16);
    bus_rd(1, v); chk("R9 status after byte", v, 8'h84);
    chk("R12 irq on done", irq, 1);
    bus_rd(2, v); chk("R5 loopback phase0", v, 8'hA5);
    bus_rd(1, v); chk("R9 rx empty after pop", v, 8'h85);
    bus_wr(1, 8'h00); bus_rd(1, v); chk("R10 write 0 no effect", v, 8'h85);
    bus_wr(1, 8'h80); bus_rd(1, v); chk("R10 w1c done", v, 8'h05);
    chk("R12 irq cleared", irq, 0);

    bus_wr(0, 8'hCD);
    xfer(8'h3C, c); chk("R3 idx1 length", c, 32);
    chk("R4 idle high", sclk, 1);
    bus_rd(2, v); chk("R6 loopback phase1", v, 8'h3C);
    bus_wr(1, 8'h80);

    bus_wr(3, 8'h01); bus_wr(0, 8'hC0);
    xfer(8'h5A, c); chk("R3 idx4 length", c, 64);
    bus_wr(3, 8'h00); bus_wr(0, 8'hC2);
    xfer(8'h96, c); chk("R3 idx2 length", c, 128);
    bus_rd(2, v); chk("R3 idx2 data", v, 8'h96);
    bus_wr(1, 8'h80);

    bus_wr(0, 8'hC0);
    bus_wr(2, 8'h81); bus_wr(2, 8'hFF);
    while (ss_n == 0) @(negedge clk);
    bus_rd(1, v); chk("R8 wcol set", v, 8'hC4);
    bus_rd(2, v); chk("R8 byte unchanged", v, 8'h81);
    bus_wr(1, 8'h80); @(negedge clk);
    chk("R12 wcol no irq", irq, 0);
    bus_wr(1, 8'h40); bus_rd(1, v); chk("R10 w1c wcol", v, 8'h05);

    bus_wr(0, 8'hC1);
    xfer(8'h11, c);
    bus_wr(2, 8'h22);
    bus_rd(1, v); chk("R13 tx busy", v, 8'h80);
    bus_rd(2, v); chk("R9 held during next", v, 8'h11);
    while (ss_n == 0) @(negedge clk);
    bus_rd(2, v); chk("R9 second byte", v, 8'h22);
    xfer(8'h33, c); xfer(8'h44, c);
    bus_rd(2, v); chk("R9 newer replaces", v, 8'h44);
    bus_wr(1, 8'h80);

    bus_wr(0, 8'hC0);
    bus_wr(2, 8'h77);
    repeat (3) @(posedge clk);
    #1ns ss_in_n = 0;
    @(posedge clk); #1ns ss_in_n = 1;
    @(negedge clk); chk("R11 aborted", ss_n, 1);
    bus_rd(0, v); chk("R11 enable cleared", v, 8'h90);
    bus_rd(1, v); chk("R11 status", v, 8'h15);
    chk("R12 irq on fault", irq, 1);
    bus_rd(2, v); chk("R11 no load", v, 8'h44);
    bus_wr(1, 8'h10); bus_rd(1, v); chk("R10 w1c modf", v, 8'h05);

    lb = 0;
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 2; r++) begin
        bus_wr(0, 8'hC0 | 8'(m << 2) | 8'(r));
        xfer(8'(37 * m + 91 * r + 5), c);
        bus_rd(2, v);
        bus_wr(1, 8'hD0);
      end
    end
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule